// File: doc/BRIEF.md
# Interrupt Redirection Table

The block routes a set of interrupt input pins to a single delivery port. Every pin has its own redirection entry that holds the vector passed to the processor, a trigger mode, a polarity, a mask and a destination byte. Software never addresses the entries directly. It writes an entry number into an index register and then reads or writes the selected 32-bit word through a data window. Each pin owns two consecutive indices: an even low word and an odd high word. Pin 0 starts at index 0x10.

When an unmasked pin becomes active, the block places a request on a valid/ready output that carries the programmed vector and destination.

- **Edge-mode pins** raise one request for each inactive-to-active transition.
- **Level-mode pins** raise a request while they are active. Each delivery sets a remote-pending flag. The pin may not deliver again until an end-of-interrupt input arrives whose vector matches its own.
- **Simultaneous pins** are served lowest-numbered first, and the others wait.

Top module: `irq_route_table`

## Requirements
- R1: After reset, every low word reads 0x0001_0000 (mask set, all other fields zero), every high word reads 0, the index register reads 0 and `dlv_valid` is 0.
- R2: Bus offset 0x00 is the index register. It holds 8 bits, written from wdata[7:0], and reads back zero-extended. Bus offset 0x10 is the data window onto the word that the index selects. The low word of pin n is at index 0x10+2n and its high word at index 0x11+2n.
- R3: The low-word fields are:
  - bits 7:0: vector.
  - bit 13: polarity (1 = active low).
  - bit 14: remote-pending flag, read-only.
  - bit 15: trigger (1 = level, 0 = edge).
  - bit 16: mask (1 = masked).

  The high word holds the destination in bits 31:24. All other bits of both words read as zero.
- R4: A window read at an index with no entry behind it returns 0, and a window write there changes no entry. Bus offsets other than 0x00 and 0x10 read 0 and ignore writes.
- R5: A masked pin produces no delivery. An edge that arrives while its pin is masked is dropped and is not delivered after a later unmask.
- R6: An edge-mode pin delivers exactly once per inactive-to-active transition, with the entry's vector and destination. Holding the pin active gives no further delivery.
- R7: With polarity set, a low pin level is the active state. The edge that delivers is high-to-low, and a return to high delivers nothing.
- R8: A level-mode pin delivers whenever it is active, unmasked and its remote-pending flag is clear, and the delivery sets the flag.
  - An end-of-interrupt whose vector differs from the entry's vector leaves the flag set.
  - A matching end-of-interrupt clears the flag. The pin then delivers again if it is still active.
- R9: When several pins are deliverable together, the lowest-numbered pin is delivered first and the others stay pending until later deliveries.
- R10: While `dlv_valid` is 1 and `dlv_ready` is 0, `dlv_valid`, `dlv_vector` and `dlv_dest` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_in | input | NPINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Receiver accepts the request |
| dlv_vector | output | 8 | Vector of the request |
| dlv_dest | output | 8 | Destination byte of the request |

## Verification
The assertions rely on the following properties of the inputs:
- `irq_in` is synchronous to `clk`.
- `dlv_ready` is driven only from the receiver's side of the handshake.
- The bus strobe lasts one cycle per access.

The bench meets these conditions by driving every input on the falling clock edge. Pins are programmed only while masked or held at their inactive level, so a configuration write cannot itself look like an edge. The stall check holds `dlv_ready` low across several cycles while two pins are pending.

// File: rtl/irt_pkg.sv
package irt_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic [7:0] vec;
  } entry_t;

  localparam entry_t ENTRY_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                   pol: 1'b0, vec: 8'h00};

  localparam int unsigned LO_VEC_LSB = 0;
  localparam int unsigned LO_POL_BIT = 13;
  localparam int unsigned LO_PND_BIT = 14;
  localparam int unsigned LO_TRG_BIT = 15;
  localparam int unsigned LO_MSK_BIT = 16;
  localparam int unsigned HI_DST_LSB = 24;

  function automatic logic [31:0] low_word(entry_t e, logic pend);
    logic [31:0] w;
    w = '0;
    w[LO_VEC_LSB +: 8] = e.vec;
    w[LO_POL_BIT]      = e.pol;
    w[LO_PND_BIT]      = pend;
    w[LO_TRG_BIT]      = e.trig;
    w[LO_MSK_BIT]      = e.mask;
    return w;
  endfunction

  function automatic logic [31:0] high_word(entry_t e);
    logic [31:0] w;
    w = '0;
    w[HI_DST_LSB +: 8] = e.dest;
    return w;
  endfunction

  function automatic entry_t apply_low(entry_t e, logic [31:0] w);
    entry_t r;
    r      = e;
    r.vec  = w[LO_VEC_LSB +: 8];
    r.pol  = w[LO_POL_BIT];
    r.trig = w[LO_TRG_BIT];
    r.mask = w[LO_MSK_BIT];
    return r;
  endfunction

  function automatic entry_t apply_high(entry_t e, logic [31:0] w);
    entry_t r;
    r      = e;
    r.dest = w[HI_DST_LSB +: 8];
    return r;
  endfunction

endpackage

// File: rtl/irt_regfile.sv
module irt_regfile
  import irt_pkg::*;
#(
  parameter int unsigned NPINS    = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned IDX_OFF  = 0,
  parameter int unsigned WIN_OFF  = 16,
  parameter int unsigned BASE_IDX = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      pend,
  output entry_t [NPINS-1:0]    cfg
);

  localparam int unsigned PW     = $clog2(NPINS);
  localparam logic [7:0]  NPINS_B = 8'(NPINS);
  localparam logic [7:0]  BASE_B  = 8'(BASE_IDX);

  logic [7:0]    idx_q;
  logic [7:0]    off;
  logic          hit;
  logic          word_hi;
  logic [PW-1:0] psel;
  logic          acc_idx;
  logic          acc_win;
  logic          wr_idx;
  logic          wr_win;
  logic          unused_wdata;

  assign off     = idx_q - BASE_B;
  assign hit     = (idx_q >= BASE_B) && ({1'b0, off[7:1]} < NPINS_B);
  assign word_hi = off[0];
  assign psel    = off[PW:1];
  assign acc_idx = bus_sel && (bus_addr == ADDR_W'(IDX_OFF));
  assign acc_win = bus_sel && (bus_addr == ADDR_W'(WIN_OFF));
  assign wr_idx  = acc_idx && bus_wr;
  assign wr_win  = acc_win && bus_wr && hit;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int n = 0; n < NPINS; n++) cfg[n] <= ENTRY_RST;
    end else begin
      if (wr_idx) idx_q <= bus_wdata[7:0];
      for (int n = 0; n < NPINS; n++) begin
        if (wr_win && (psel == PW'(n))) begin
          if (word_hi) cfg[n] <= apply_high(cfg[n], bus_wdata);
          else         cfg[n] <= apply_low(cfg[n], bus_wdata);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_idx && !bus_wr) begin
      bus_rdata = {24'h0, idx_q};
    end else if (acc_win && !bus_wr && hit) begin
      bus_rdata = word_hi ? high_word(cfg[psel])
                          : low_word(cfg[psel], pend[psel]);
    end
  end

  // R4
  window_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_win && bus_wr && !hit) |=> $stable(cfg));

endmodule

// File: rtl/irt_pin.sv
module irt_pin
  import irt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq,
  input  entry_t     cfg,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  input  logic       take,
  output logic       req,
  output logic       pend
);

  logic active;
  logic active_q;
  logic rise;
  logic edge_q;
  logic eoi_hit;
  logic unused_cfg;

  assign active  = irq ^ cfg.pol;
  assign rise    = active && !active_q;
  assign eoi_hit = eoi_valid && (eoi_vector == cfg.vec);
  assign unused_cfg = ^cfg.dest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      edge_q   <= 1'b0;
      pend     <= 1'b0;
    end else begin
      active_q <= active;
      if (cfg.mask || cfg.trig) edge_q <= 1'b0;
      else if (rise)            edge_q <= 1'b1;
      else if (take)            edge_q <= 1'b0;
      if (!cfg.trig)            pend <= 1'b0;
      else if (take)            pend <= 1'b1;
      else if (eoi_hit)         pend <= 1'b0;
    end
  end

  assign req = cfg.trig ? (active && !cfg.mask && !pend)
                        : (edge_q && !cfg.mask);

  // R5
  masked_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && cfg.mask));

  // R8
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(take));

endmodule

// File: rtl/irt_arbiter.sv
module irt_arbiter #(
  parameter int unsigned NPINS = 16,
  localparam int unsigned PW   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] req,
  input  logic             free,
  output logic [NPINS-1:0] take,
  output logic [PW-1:0]    sel,
  output logic             fire
);

  function automatic logic [PW-1:0] lowest_index(logic [NPINS-1:0] r);
    logic [PW-1:0] s;
    s = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (r[i]) s = PW'(i);
    end
    return s;
  endfunction

  assign sel  = lowest_index(req);
  assign fire = free && (|req);

  always_comb begin
    take = '0;
    if (fire) take[sel] = 1'b1;
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  // R9
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~req) == '0);

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irt_pkg::*;
#(
  parameter int unsigned NPINS    = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned IDX_OFF  = 0,
  parameter int unsigned WIN_OFF  = 16,
  parameter int unsigned BASE_IDX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_in,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [7:0]        dlv_vector,
  output logic [7:0]        dlv_dest
);

  localparam int unsigned PW = $clog2(NPINS);

  entry_t [NPINS-1:0] cfg;
  logic   [NPINS-1:0] req;
  logic   [NPINS-1:0] pend;
  logic   [NPINS-1:0] take;
  logic   [PW-1:0]    sel;
  logic               fire;
  logic               out_free;

  irt_regfile #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .IDX_OFF(IDX_OFF),
    .WIN_OFF(WIN_OFF), .BASE_IDX(BASE_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend), .cfg(cfg)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    irt_pin u_pin (
      .clk(clk), .rst_n(rst_n), .irq(irq_in[n]), .cfg(cfg[n]),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .take(take[n]), .req(req[n]), .pend(pend[n])
    );
  end

  assign out_free = !dlv_valid || dlv_ready;

  irt_arbiter #(.NPINS(NPINS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .free(out_free),
    .take(take), .sel(sel), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_vector <= '0;
      dlv_dest   <= '0;
    end else if (fire) begin
      dlv_valid  <= 1'b1;
      dlv_vector <= cfg[sel].vec;
      dlv_dest   <= cfg[sel].dest;
    end else if (dlv_ready) begin
      dlv_valid  <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=>
      (dlv_valid && $stable(dlv_vector) && $stable(dlv_dest)));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !dlv_valid);

endmodule

// File: tb/irq_route_table_tb.sv
`timescale 1ns/1ps
module irq_route_table_tb;

  localparam int NPINS = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  irq_in = '0;
  logic              eoi_valid = 1'b0;
  logic [7:0]        eoi_vector = '0;
  logic              dlv_valid;
  logic              dlv_ready = 1'b1;
  logic [7:0]        dlv_vector;
  logic [7:0]        dlv_dest;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int dcount = 0;
  logic [7:0] last_vec = '0;
  logic [7:0] last_dest = '0;
  logic [7:0] vlog [64];

  always #2.5 clk = ~clk;

  irq_route_table #(.NPINS(NPINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest)
  );

  always @(posedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      vlog[dcount[5:0]] <= dlv_vector;
      last_vec  <= dlv_vector;
      last_dest <= dlv_dest;
      dcount    <= dcount + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    tests = tests + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_read(8'h10, d);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  // index, write data, expected read-back, kind (0: field layout R3, 1: unmapped R4)
  localparam int NV = 7;
  localparam logic [72:0] VEC [NV] = '{
    {8'h10, 32'hFFFF_FFFF, 32'h0001_A0FF, 1'b0},
    {8'h11, 32'hFFFF_FFFF, 32'hFF00_0000, 1'b0},
    {8'h2E, 32'h0001_2055, 32'h0001_2055, 1'b0},
    {8'h2F, 32'h1234_5678, 32'h1200_0000, 1'b0},
    {8'h20, 32'h0000_80D1, 32'h0000_80D1, 1'b0},
    {8'h30, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    {8'h05, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}
  };

  initial begin
    logic [31:0] r;
    int base;
    run(4);
    rst_n = 1'b1;
    run(2);

    // R1 reset state
    bus_read(8'h00, r);      check("R1 index", r, 32'h0);
    win_read(8'h10, r);      check("R1 pin0 low", r, 32'h0001_0000);
    win_read(8'h2F, r);      check("R1 pin15 high", r, 32'h0);
    win_read(8'h1E, r);      check("R1 pin7 low", r, 32'h0001_0000);
    check("R1 dlv_valid", {31'h0, dlv_valid}, 32'h0);

    // R2 index register and window
    bus_write(8'h00, 32'hABCD_EF25);
    bus_read(8'h00, r);      check("R2 index readback", r, 32'h25);
    win_write(8'h13, 32'h5A00_0000);
    win_read(8'h13, r);      check("R2 pin1 high", r, 32'h5A00_0000);
    win_read(8'h12, r);      check("R2 pin1 low untouched", r, 32'h0001_0000);

    for (int i = 0; i < NV; i++) begin
      win_write(VEC[i][72:65], VEC[i][64:33]);
      win_read(VEC[i][72:65], r);
      if (VEC[i][0]) check("R4 unmapped index", r, VEC[i][32:1]);
      else           check("R3 field layout", r, VEC[i][32:1]);
    end
    win_read(8'h10, r);      check("R4 pin0 after unmapped writes", r, 32'h0001_A0FF);

    // R4 other bus offsets
    bus_write(8'h00, 32'h0000_0022);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, r);      check("R4 offset 04 read", r, 32'h0);
    bus_read(8'h00, r);      check("R4 index kept", r, 32'h22);
    win_read(8'h22, r);      check("R4 pin9 kept", r, 32'h0001_0000);

    // R6 edge mode
    win_write(8'h14, 32'h0000_0042);
    win_write(8'h15, 32'h0700_0000);
    base = dcount;
    irq_in[2] = 1'b1;
    run(10);
    check("R6 one delivery", dcount - base, 1);
    check("R6 vector", {24'h0, last_vec}, 32'h42);
    check("R6 dest", {24'h0, last_dest}, 32'h07);
    run(10);
    check("R6 held active no repeat", dcount - base, 1);
    irq_in[2] = 1'b0; run(3);
    irq_in[2] = 1'b1; run(10);
    check("R6 second edge", dcount - base, 2);

    // R5 mask
    irq_in[2] = 1'b0;
    win_write(8'h14, 32'h0001_0042);
    base = dcount;
    irq_in[2] = 1'b1; run(10);
    check("R5 masked edge", dcount - base, 0);
    win_write(8'h14, 32'h0000_0042);
    run(10);
    check("R5 dropped edge after unmask", dcount - base, 0);
    irq_in[2] = 1'b0;

    // R7 active-low polarity
    irq_in[3] = 1'b1; run(2);
    win_write(8'h16, 32'h0000_2033);
    run(5);
    base = dcount;
    check("R7 no delivery at idle high", dcount - base, 0);
    irq_in[3] = 1'b0; run(10);
    check("R7 falling edge delivers", dcount - base, 1);
    check("R7 vector", {24'h0, last_vec}, 32'h33);
    irq_in[3] = 1'b1; run(10);
    check("R7 rising edge ignored", dcount - base, 1);

    // R8 level mode
    win_write(8'h18, 32'h0000_8064);
    base = dcount;
    irq_in[4] = 1'b1; run(10);
    check("R8 first delivery", dcount - base, 1);
    win_read(8'h18, r);      check("R8 pending flag set", r, 32'h0000_C064);
    run(10);
    check("R8 waits for eoi", dcount - base, 1);
    eoi(8'h65); run(5);
    check("R8 wrong eoi no effect", dcount - base, 1);
    win_read(8'h18, r);      check("R8 flag kept", r, 32'h0000_C064);
    eoi(8'h64); run(10);
    check("R8 redelivery after eoi", dcount - base, 2);
    irq_in[4] = 1'b0; run(2);
    eoi(8'h64); run(10);
    check("R8 inactive no delivery", dcount - base, 2);
    win_read(8'h18, r);      check("R8 flag cleared", r, 32'h0000_8064);

    // R9 priority, R10 stall
    win_write(8'h1A, 32'h0000_0050);
    win_write(8'h1C, 32'h0000_0060);
    @(negedge clk);
    dlv_ready = 1'b0;
    base = dcount;
    irq_in[5] = 1'b1; irq_in[6] = 1'b1;
    run(6);
    check("R9 lowest first valid", {31'h0, dlv_valid}, 32'h1);
    check("R9 lowest first vector", {24'h0, dlv_vector}, 32'h50);
    run(6);
    check("R10 held valid", {31'h0, dlv_valid}, 32'h1);
    check("R10 held vector", {24'h0, dlv_vector}, 32'h50);
    dlv_ready = 1'b1;
    run(6);
    check("R9 both delivered", dcount - base, 2);
    check("R9 order first", {24'h0, vlog[base[5:0]]}, 32'h50);
    check("R9 order second", {24'h0, vlog[6'(base + 1)]}, 32'h60);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule